// File: doc/BRIEF.md
# GPIO bank register block with mask-steered line configuration

The block holds the registers of one GPIO bank of up to 32 lines behind a small memory-mapped bus with 32-bit word addressing. A write to a register takes effect on the clock edge that samples the access. A read is captured on the same edge and appears on the read-data output until the next read. Every line owns a configuration word that selects its function, direction, pull-up, pull-down, open-drain, Schmitt input and drive strength. These words are not mapped one register per line. Software first loads a line-select mask and then accesses one shared configuration window. A window write lands in every selected line at once. A window read returns the word of the lowest selected line.

The output latch is changed only through a set register and a clear register, so that bits written as 0 never disturb other lines. The latch can be read back. The pin levels pass through a two-flop synchronizer before they can be read. All configuration fields drive per-line pad control outputs directly. Banks are replicated at a 0x40-byte (16-word) stride, so the block decodes a 4-bit word address.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset the mask, the output latch, the read data and every configuration word are 0. All pad outputs are therefore 0, which means a GPIO input with no pull.
- R2: Word address 0 (byte 0x00) is the line mask. A write stores bits [NUM_LINES-1:0] and a read returns them.
- R3: A write to word address 1 (byte 0x04, the configuration window) stores the data into the configuration word of every line whose mask bit is 1. All other lines keep their words.
- R4: In a configuration word, bits [2:0] hold the function (0 = GPIO, 1..7 = peripheral), bit 8 the direction (1 = output), bit 9 the pull-up, bit 10 the pull-down, bit 14 open-drain, bit 15 Schmitt and bits [17:16] the drive strength. These fields drive pad_func, pad_oe, pad_pu, pad_pd, pad_od, pad_schmitt and pad_drv of that line. All other bits are not stored and read as 0.
- R5: A read of the configuration window returns the word of the lowest-numbered line selected in the mask, or 0 when the mask is 0.
- R6: A write to word address 4 (byte 0x10) sets each latch bit written as 1. Bits written as 0 are unchanged.
- R7: A write to word address 5 (byte 0x14) clears each latch bit written as 1. Bits written as 0 are unchanged.
- R8: Word address 6 (byte 0x18) reads the output latch. The latch also drives pad_out.
- R9: Word address 2 (byte 0x08) reads the pin levels through a two-flop synchronizer. A read whose access edge is the first or second edge after a pin change returns the old level. From the third edge on it returns the new level.
- R10: Reads of unmapped word addresses return 0. Writes to read-only or unmapped addresses change no state.
- R11: Read data changes only on a read access and is valid from the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_LINES | Asynchronous pin levels |
| pad_out | output | NUM_LINES | Output latch |
| pad_oe | output | NUM_LINES | Output enable per line |
| pad_pu | output | NUM_LINES | Pull-up enable |
| pad_pd | output | NUM_LINES | Pull-down enable |
| pad_od | output | NUM_LINES | Open-drain enable |
| pad_schmitt | output | NUM_LINES | Schmitt input enable |
| pad_func | output | 3*NUM_LINES | Function select, 3 bits per line |
| pad_drv | output | 2*NUM_LINES | Drive strength, 2 bits per line |

## Verification
Random masks cover the empty mask, single-line masks, dense masks and the full mask. Window writes through these masks separate a broadcast that reaches every selected line from one that leaks into unselected lines. Window reads after them separate a lowest-line pick from a highest-line pick or an OR of the selected words. Random set and clear words with mixed bits show whether 0 bits stay untouched. A directed pin step, read on each of the first three edges after it, confirms the depth of the synchronizer.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // word addresses inside a bank
    localparam logic [ADDR_W-1:0] A_LINE_MASK = 4'd0;
    localparam logic [ADDR_W-1:0] A_CFG_WIN   = 4'd1;
    localparam logic [ADDR_W-1:0] A_PIN_LVL   = 4'd2;
    localparam logic [ADDR_W-1:0] A_OUT_SET   = 4'd4;
    localparam logic [ADDR_W-1:0] A_OUT_CLR   = 4'd5;
    localparam logic [ADDR_W-1:0] A_OUT_LVL   = 4'd6;

    typedef struct packed {
        logic [1:0] drv;
        logic       schmitt;
        logic       odrain;
        logic       pull_dn;
        logic       pull_up;
        logic       dir_out;
        logic [2:0] func;
    } line_cfg_t;

    localparam int CFG_W = $bits(line_cfg_t);

    function automatic line_cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
        line_cfg_t c;
        c.func    = w[2:0];
        c.dir_out = w[8];
        c.pull_up = w[9];
        c.pull_dn = w[10];
        c.odrain  = w[14];
        c.schmitt = w[15];
        c.drv     = w[17:16];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(input line_cfg_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[2:0]   = c.func;
        w[8]     = c.dir_out;
        w[9]     = c.pull_up;
        w[10]    = c.pull_dn;
        w[14]    = c.odrain;
        w[15]    = c.schmitt;
        w[17:16] = c.drv;
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] sync_d, sync_q;

    always_comb begin
        meta_d = async_in;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q;

    // R9: second stage always follows the first
    p_sync_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_q == $past(meta_q)));
endmodule

// File: rtl/gpio_line_cfg.sv
module gpio_line_cfg
    import gpio_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  line_cfg_t wr_cfg,
    output line_cfg_t cfg
);
    line_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = wr_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R3: an unselected line keeps its word
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
    // R3: a selected line takes the written word
    p_cfg_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == $past(wr_cfg)));
endmodule

// File: rtl/gpio_low_pick.sv
module gpio_low_pick
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]       sel_mask,
    input  line_cfg_t [N-1:0]  cfg_all,
    output logic [DATA_W-1:0]  pick_word
);
    logic [N-1:0] first_hot;
    line_cfg_t    pick_cfg;

    always_comb begin
        logic seen;
        seen      = 1'b0;
        first_hot = '0;
        pick_cfg  = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_mask[i] && !seen) begin
                seen         = 1'b1;
                first_hot[i] = 1'b1;
                pick_cfg     = cfg_all[i];
            end
        end
        pick_word = cfg_pack(pick_cfg);
    end

    // R5: at most one line chosen, and only a selected one
    always_comb begin
        a_one_pick_r5: assert ($onehot0(first_hot));
        a_pick_in_mask_r5: assert ((first_hot & ~sel_mask) == '0);
        a_empty_zero_r5: assert ((sel_mask != '0) || (pick_word == '0));
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [3:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_LINES-1:0]   pin_in,
    output logic [NUM_LINES-1:0]   pad_out,
    output logic [NUM_LINES-1:0]   pad_oe,
    output logic [NUM_LINES-1:0]   pad_pu,
    output logic [NUM_LINES-1:0]   pad_pd,
    output logic [NUM_LINES-1:0]   pad_od,
    output logic [NUM_LINES-1:0]   pad_schmitt,
    output logic [3*NUM_LINES-1:0] pad_func,
    output logic [2*NUM_LINES-1:0] pad_drv
);
    localparam int N = NUM_LINES;

    typedef struct packed {
        logic [N-1:0]      mask;
        logic [N-1:0]      latch;
        logic [DATA_W-1:0] rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic                wr_acc, rd_acc, cfg_wr;
    logic [N-1:0]        pin_sync;
    line_cfg_t [N-1:0]   cfg_all;
    line_cfg_t           wr_cfg;
    logic [DATA_W-1:0]   win_word;

    assign wr_acc = bus_sel &&  bus_wr;
    assign rd_acc = bus_sel && !bus_wr;
    assign cfg_wr = wr_acc && (bus_addr == A_CFG_WIN);
    assign wr_cfg = cfg_unpack(bus_wdata);

    gpio_in_sync #(.W(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        gpio_line_cfg u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_wr && st_q.mask[i]),
            .wr_cfg (wr_cfg),
            .cfg    (cfg_all[i])
        );
        assign pad_oe[i]          = cfg_all[i].dir_out;
        assign pad_pu[i]          = cfg_all[i].pull_up;
        assign pad_pd[i]          = cfg_all[i].pull_dn;
        assign pad_od[i]          = cfg_all[i].odrain;
        assign pad_schmitt[i]     = cfg_all[i].schmitt;
        assign pad_func[3*i +: 3] = cfg_all[i].func;
        assign pad_drv[2*i +: 2]  = cfg_all[i].drv;
    end

    gpio_low_pick #(.N(N)) u_pick (
        .sel_mask  (st_q.mask),
        .cfg_all   (cfg_all),
        .pick_word (win_word)
    );

    always_comb begin
        st_d = st_q;
        if (wr_acc) begin
            unique case (bus_addr)
                A_LINE_MASK: st_d.mask  = bus_wdata[N-1:0];
                A_OUT_SET:   st_d.latch = st_q.latch |  bus_wdata[N-1:0];
                A_OUT_CLR:   st_d.latch = st_q.latch & ~bus_wdata[N-1:0];
                default:     ;
            endcase
        end
        if (rd_acc) begin
            unique case (bus_addr)
                A_LINE_MASK: st_d.rdata = DATA_W'(st_q.mask);
                A_CFG_WIN:   st_d.rdata = win_word;
                A_PIN_LVL:   st_d.rdata = DATA_W'(pin_sync);
                A_OUT_LVL:   st_d.rdata = DATA_W'(st_q.latch);
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pad_out   = st_q.latch;

    // R6: written ones end up high
    p_set_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr == A_OUT_SET) |=>
        ((pad_out & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));
    // R7: written ones end up low
    p_clr_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr == A_OUT_CLR) |=>
        ((pad_out & $past(bus_wdata[N-1:0])) == '0));
    // R10: latch untouched without set or clear writes
    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && (bus_addr == A_OUT_SET || bus_addr == A_OUT_CLR)) |=> $stable(pad_out));
    // R2: mask only moves on a mask write
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && bus_addr == A_LINE_MASK) |=> $stable(st_q.mask));
    // R11: read data holds without a read
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(bus_rdata));
endmodule

// File: tb/sim_gpio_bank_regs.sv
`timescale 1ns/1ps
module sim_gpio_bank_regs;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_pu, pad_pd, pad_od, pad_schmitt;
    logic [3*N-1:0] pad_func;
    logic [2*N-1:0] pad_drv;

    int checks = 0, errors = 0;
    logic [N-1:0]  m_mask = '0, m_latch = '0;
    logic [31:0]   m_cfg [N];

    always #2 clk = ~clk;

    gpio_bank_regs #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_od(pad_od), .pad_schmitt(pad_schmitt),
        .pad_func(pad_func), .pad_drv(pad_drv));

    function automatic logic [31:0] keep_bits(input logic [31:0] w);
        return w & 32'h0003_C707;
    endfunction

    function automatic logic [31:0] low_pick(input logic [N-1:0] m);
        for (int i = 0; i < N; i++)
            if (m[i]) return m_cfg[i];
        return 32'h0;
    endfunction

    function automatic logic [31:0] pads_of(input int i);
        logic [31:0] w;
        w = '0;
        w[2:0] = pad_func[3*i +: 3];
        w[8] = pad_oe[i]; w[9] = pad_pu[i]; w[10] = pad_pd[i];
        w[14] = pad_od[i]; w[15] = pad_schmitt[i];
        w[17:16] = pad_drv[2*i +: 2];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_pads(input string req);
        for (int i = 0; i < N; i++) chk(req, pads_of(i), m_cfg[i]);
        chk(req, pad_out, m_latch);
    endtask

    task automatic do_mask(input logic [N-1:0] m);
        bwrite(4'd0, m); m_mask = m;
    endtask

    task automatic do_cfg(input logic [31:0] w);
        bwrite(4'd1, w);
        for (int i = 0; i < N; i++) if (m_mask[i]) m_cfg[i] = keep_bits(w);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, w;
        for (int i = 0; i < N; i++) m_cfg[i] = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", bus_rdata, 32'h0);
        check_pads("R1");
        rst_n = 1'b1;
        bread(4'd0, r); chk("R1", r, 32'h0);
        bread(4'd1, r); chk("R5 empty mask", r, 32'h0);

        // directed: R2 mask, R3 broadcast, R4 fields
        do_mask(32'h8000_0001);
        bread(4'd0, r); chk("R2", r, 32'h8000_0001);
        do_cfg(32'hFFFF_FFFF);
        check_pads("R3/R4 all ones");
        bread(4'd1, r); chk("R4 unused bits read 0", r, 32'h0003_C707);
        do_mask(32'h0000_0100);
        do_cfg(32'h0002_0203);
        do_mask(32'h8000_0100);
        bread(4'd1, r); chk("R5 lowest line", r, 32'h0002_0203);
        do_mask(32'h0);
        do_cfg(32'h0000_0105);
        check_pads("R3 empty mask write ignored");

        // R6/R7/R8 set and clear
        bwrite(4'd4, 32'hF0F0_00FF); m_latch |= 32'hF0F0_00FF;
        bwrite(4'd5, 32'h3000_000F); m_latch &= ~32'h3000_000F;
        bread(4'd6, r); chk("R6/R7/R8", r, m_latch);

        // R10 read-only and unmapped writes ignored
        bwrite(4'd2, 32'hFFFF_FFFF);
        bwrite(4'd6, 32'hFFFF_FFFF);
        bwrite(4'd9, 32'hFFFF_FFFF);
        bread(4'd6, r); chk("R10 write to status ignored", r, m_latch);
        bread(4'd0, r); chk("R10 mask untouched", r, 32'h0);
        check_pads("R10 pads untouched");
        bread(4'd3, r); chk("R10 unmapped read", r, 32'h0);
        bread(4'd15, r); chk("R10 unmapped read", r, 32'h0);

        // R9 synchronizer depth
        pin_in = 32'h1234_5678;
        repeat (4) @(negedge clk);
        bread(4'd2, r); chk("R9 settled", r, 32'h1234_5678);
        @(negedge clk);
        pin_in = 32'hA5A5_0F0F;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd2;
        @(negedge clk); chk("R9 edge1 old", bus_rdata, 32'h1234_5678);
        @(negedge clk); chk("R9 edge2 old", bus_rdata, 32'h1234_5678);
        @(negedge clk); chk("R9 edge3 new", bus_rdata, 32'hA5A5_0F0F);
        bus_sel = 1'b0;
        // R11 read data holds while idle
        repeat (3) @(negedge clk);
        chk("R11 hold", bus_rdata, 32'hA5A5_0F0F);

        // random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 6);
            w  = $urandom;
            case (op)
                0: begin
                    case ($urandom_range(0, 3))
                        0: do_mask(32'h0);
                        1: do_mask(32'h1 << $urandom_range(0, 31));
                        2: do_mask(32'hFFFF_FFFF);
                        default: do_mask(w);
                    endcase
                end
                1: do_cfg(w);
                2: begin bwrite(4'd4, w); m_latch |= w; end
                3: begin bwrite(4'd5, w); m_latch &= ~w; end
                4: begin bread(4'd1, r); chk("R5 random", r, low_pick(m_mask)); end
                5: begin bread(4'd6, r); chk("R8 random", r, m_latch); end
                default: begin bread(4'd0, r); chk("R2 random", r, m_mask); end
            endcase
            if (k % 50 == 49) check_pads("R3/R4 random");
        end
        check_pads("R4 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule